// File: doc/BRIEF.md
# Reset-Class Configuration Register Bank

This block holds a small set of configuration registers whose contents must outlive different kinds of reset. Each register belongs to one of three reset classes. The first class is cleared only by the global power-on reset. The second class holds the power-management wake context and survives a bus reset while wake signalling is enabled. The third class is cleared by either reset. A suspend input blocks both reset inputs and freezes the bank, so the stored contents stay intact while the system sleeps.

The registers are written through a simple select/data write port. Their contents appear directly on output ports. One register per function carries a wake-enable bit, a data-select field and a power-state field. A status flag reports when wake signalling is enabled and every function sits in the deepest power state. Both reset inputs are active-low. Each one asserts asynchronously and is released through a synchroniser of `SYNC_STAGES` flops.

Top module: `rstctx_bank`

## Requirements
- R1: While the global reset is active, every register returns to its default, whatever the wake-enable bits hold. The defaults are: sub_vendor 0, sub_id 0, route_map `ROUTE_DEF` (0x0001000), cold-wake support bit 1, gp_ctrl 0, and every pm_ctl 0.
- R2: A bus reset never alters sub_vendor, sub_id, route_map or pm_cap.
- R3: If any function's wake-enable bit (pm_ctl bit 8) is 1 when a bus reset acts, the wake-enable and data-select (pm_ctl bits 12:9) fields of every function keep their values.
- R4: If no wake-enable bit is set when a bus reset acts, the wake-enable and data-select fields of every function are cleared.
- R5: A bus reset always clears gp_ctrl and the power-state field (pm_ctl bits 1:0) of every function.
- R6: While `susp` is 1, no reset input and no write changes any output, and no reset is remembered after `susp` falls if its input was released before that.
- R7: `d3_flag` is 1 exactly when at least one wake-enable bit is set and every function's power state is 3.
- R8: pm_cap reads as follows: bit 15 is the cold-wake support bit, bit 4 mirrors bit 15, bits 2:0 read 010, and all other bits read 0. A write with select 3 changes only bit 15, taken from wr_data bit 15.
- R9: A write is ignored while a reset input is low. It is also ignored on the first `SYNC_STAGES` (2) rising edges after the reset input is released. A write is taken on the next edge after those.
- R10: The write select codes are: 0 sub_vendor, 1 sub_id, 2 route_map (all `DATA_W` bits), 4 gp_ctrl, and 5+f pm_ctl of function f. pm_ctl stores only bits 12:9, 8 and 1:0 and reads 0 elsewhere. sub_vendor, sub_id and gp_ctrl take wr_data bits 15:0.
- R11: While the global reset is in effect, the bank behaves as if the bus reset were also active. A bus reset that is still held after the global release keeps blocking writes and clearing the bus-reset class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| gbl_rst_n | input | 1 | Global power-on reset, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| susp | input | 1 | Suspend: blocks both resets and freezes the bank |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W | Register select code |
| wr_data | input | DATA_W | Write data |
| sub_vendor | output | 16 | Subsystem vendor identifier (global-only class) |
| sub_id | output | 16 | Subsystem identifier (global-only class) |
| route_map | output | DATA_W | Pin routing field (global-only class) |
| pm_cap | output | 16 | Power-management capability word |
| pm_ctl | output | NUM_FUNC x 16 | Per-function power-management control word |
| gp_ctrl | output | 16 | General control register (cleared by either reset) |
| d3_flag | output | 1 | Wake enabled and all functions in power state 3 |

## Verification
The assertions assume two things about the inputs. First, the bus reset is never released before the global reset. Second, every input change is seen by the clock as a clean level that lasts at least one cycle. The stimulus meets both by changing inputs only on falling clock edges. It also always releases the bus reset together with or after the global one, including one sequence that holds it several cycles longer on purpose. Reset pulses during suspend are released before suspend falls, because a reset still held at that moment would assert at once. That case lies outside the hold guarantee.

// File: rtl/rstctx_pkg.sv
package rstctx_pkg;

    // write select codes
    localparam int SEL_SUBVEN    = 0;
    localparam int SEL_SUBID     = 1;
    localparam int SEL_ROUTE     = 2;
    localparam int SEL_PMCAP     = 3;
    localparam int SEL_CTRL      = 4;
    localparam int SEL_FUNC_BASE = 5;

    // field positions inside the per-function control word
    localparam int PMC_PSTATE_LO = 0;
    localparam int PMC_PME_EN    = 8;
    localparam int PMC_DSEL_LO   = 9;
    localparam int PMCAP_D3C     = 15;

    localparam logic [1:0] PSTATE_D3   = 2'd3;
    localparam logic [2:0] PMCAP_VER   = 3'b010;

    typedef struct packed {
        logic       pme_en;
        logic [3:0] dsel;
        logic [1:0] pstate;
    } func_ctx_t;

    function automatic logic [15:0] pack_pmctl(func_ctx_t c);
        return {3'b000, c.dsel, c.pme_en, 6'b000000, c.pstate};
    endfunction

endpackage

// File: rtl/rstctx_sync.sv
// Reset synchroniser: asynchronous assertion, synchronous release.
// Suspend blocks the input and freezes the chain.
module rstctx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    input  logic susp,
    output logic rst_act
);

    logic              arst;
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    assign arst = ~rst_in_n & ~susp;

    always_comb begin
        chain_d = chain_q;
        if (!susp) begin
            chain_d = {chain_q[STAGES-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign rst_act = ~chain_q[STAGES-1];

endmodule

// File: rtl/rstctx_func.sv
// Per-function wake-context slice: wake enable and data select form the
// context class, the power state is cleared by any reset.
module rstctx_func
    import rstctx_pkg::*;
(
    input  logic      clk,
    input  logic      grst_act,
    input  logic      brst_act,
    input  logic      susp,
    input  logic      keep,
    input  logic      wr_hit,
    input  func_ctx_t wr_val,
    output func_ctx_t ctx
);

    func_ctx_t ctx_d;
    func_ctx_t ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (!susp) begin
            if (brst_act) begin
                ctx_d.pstate = '0;
                if (!keep) begin
                    ctx_d.pme_en = 1'b0;
                    ctx_d.dsel   = '0;
                end
            end else if (wr_hit) begin
                ctx_d = wr_val;
            end
        end
    end

    always_ff @(posedge clk or posedge grst_act) begin
        if (grst_act) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ctx = ctx_q;

endmodule

// File: rtl/rstctx_bank.sv
// Register bank with three reset classes: global-only, wake context,
// and plain (cleared by either reset).
module rstctx_bank
    import rstctx_pkg::*;
#(
    parameter int                 NUM_FUNC    = 2,
    parameter int                 DATA_W      = 28,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0]  ROUTE_DEF   = 28'h0001000,
    parameter logic               D3C_DEF     = 1'b1,
    localparam int                SEL_W       = $clog2(SEL_FUNC_BASE + NUM_FUNC)
) (
    input  logic                       clk,
    input  logic                       gbl_rst_n,
    input  logic                       bus_rst_n,
    input  logic                       susp,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [15:0]                sub_vendor,
    output logic [15:0]                sub_id,
    output logic [DATA_W-1:0]          route_map,
    output logic [15:0]                pm_cap,
    output logic [NUM_FUNC-1:0][15:0]  pm_ctl,
    output logic [15:0]                gp_ctrl,
    output logic                       d3_flag
);

    typedef struct packed {
        logic [15:0]       sub_ven;
        logic [15:0]       sub_id;
        logic [DATA_W-1:0] route;
        logic              d3c;
        logic [15:0]       ctrl;
    } bank_t;

    localparam bank_t BANK_DEF = '{
        sub_ven: 16'h0000,
        sub_id:  16'h0000,
        route:   ROUTE_DEF,
        d3c:     D3C_DEF,
        ctrl:    16'h0000
    };

    logic grst_act;
    logic bsync_act;
    logic brst_act;
    logic wr_ok;
    logic keep;

    logic [NUM_FUNC-1:0] pen_vec;
    logic [NUM_FUNC-1:0] d3_vec;
    func_ctx_t           ctx [NUM_FUNC];

    bank_t bank_d;
    bank_t bank_q;

    // ---------------------------------------------------------------
    // reset conditioning
    // ---------------------------------------------------------------
    rstctx_sync #(.STAGES(SYNC_STAGES)) i_gsync (
        .clk      (clk),
        .rst_in_n (gbl_rst_n),
        .susp     (susp),
        .rst_act  (grst_act)
    );

    rstctx_sync #(.STAGES(SYNC_STAGES)) i_bsync (
        .clk      (clk),
        .rst_in_n (bus_rst_n),
        .susp     (susp),
        .rst_act  (bsync_act)
    );

    // a global reset implies a bus reset
    assign brst_act = bsync_act | grst_act;
    assign wr_ok    = wr_en & ~susp & ~brst_act;

    // ---------------------------------------------------------------
    // global-only and plain registers
    // ---------------------------------------------------------------
    always_comb begin
        bank_d = bank_q;
        if (!susp) begin
            if (brst_act) begin
                bank_d.ctrl = '0;
            end else if (wr_en) begin
                if (wr_sel == SEL_W'(SEL_SUBVEN)) begin
                    bank_d.sub_ven = wr_data[15:0];
                end
                if (wr_sel == SEL_W'(SEL_SUBID)) begin
                    bank_d.sub_id = wr_data[15:0];
                end
                if (wr_sel == SEL_W'(SEL_ROUTE)) begin
                    bank_d.route = wr_data;
                end
                if (wr_sel == SEL_W'(SEL_PMCAP)) begin
                    bank_d.d3c = wr_data[PMCAP_D3C];
                end
                if (wr_sel == SEL_W'(SEL_CTRL)) begin
                    bank_d.ctrl = wr_data[15:0];
                end
            end
        end
    end

    always_ff @(posedge clk or posedge grst_act) begin
        if (grst_act) begin
            bank_q <= BANK_DEF;
        end else begin
            bank_q <= bank_d;
        end
    end

    // ---------------------------------------------------------------
    // per-function wake context
    // ---------------------------------------------------------------
    assign keep = |pen_vec;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        logic      hit;
        func_ctx_t wv;

        assign hit = wr_ok && (wr_sel == SEL_W'(SEL_FUNC_BASE + f));
        assign wv  = '{
            pme_en: wr_data[PMC_PME_EN],
            dsel:   wr_data[PMC_DSEL_LO +: 4],
            pstate: wr_data[PMC_PSTATE_LO +: 2]
        };

        rstctx_func i_func (
            .clk      (clk),
            .grst_act (grst_act),
            .brst_act (brst_act),
            .susp     (susp),
            .keep     (keep),
            .wr_hit   (hit),
            .wr_val   (wv),
            .ctx      (ctx[f])
        );

        assign pen_vec[f] = ctx[f].pme_en;
        assign d3_vec[f]  = (ctx[f].pstate == PSTATE_D3);
        assign pm_ctl[f]  = pack_pmctl(ctx[f]);
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    assign sub_vendor = bank_q.sub_ven;
    assign sub_id     = bank_q.sub_id;
    assign route_map  = bank_q.route;
    assign gp_ctrl    = bank_q.ctrl;
    assign pm_cap     = {bank_q.d3c, 10'b0, bank_q.d3c, 1'b0, PMCAP_VER};
    assign d3_flag    = keep & (&d3_vec);

endmodule

// File: rtl/rstctx_chk.sv
module rstctx_chk #(
    parameter int                NUM_FUNC  = 2,
    parameter int                DATA_W    = 28,
    parameter logic [DATA_W-1:0] ROUTE_DEF = 28'h0001000
) (
    input logic                      clk,
    input logic                      gbl_rst_n,
    input logic                      bus_rst_n,
    input logic                      susp,
    input logic [15:0]               sub_vendor,
    input logic [15:0]               sub_id,
    input logic [DATA_W-1:0]         route_map,
    input logic [15:0]               pm_cap,
    input logic [NUM_FUNC-1:0][15:0] pm_ctl,
    input logic [15:0]               gp_ctrl,
    input logic                      d3_flag
);

    logic pme_any;
    logic all_d3;
    logic ctx_zero;
    logic grst_seen = 1'b0;

    always_comb begin
        pme_any  = 1'b0;
        all_d3   = 1'b1;
        ctx_zero = 1'b1;
        for (int f = 0; f < NUM_FUNC; f++) begin
            pme_any  = pme_any | pm_ctl[f][8];
            all_d3   = all_d3 & (pm_ctl[f][1:0] == 2'd3);
            ctx_zero = ctx_zero & (pm_ctl[f][12:8] == 5'd0);
        end
    end

    // R1: one cycle after an unmasked global reset, all defaults are held
    always @(posedge clk) begin
        if (grst_seen) begin
            assert_gbl_defaults_R1: assert (sub_vendor == 16'h0 && sub_id == 16'h0 &&
                                            route_map == ROUTE_DEF && gp_ctrl == 16'h0 &&
                                            pm_ctl == '0 && pm_cap[15] == 1'b1)
                else $error("global reset left a non-default value");
        end
        grst_seen <= !gbl_rst_n && !susp;
    end

    assert_bus_keeps_global_R2: assert property (@(posedge clk) disable iff (!gbl_rst_n)
        (!bus_rst_n && !susp) |=> ($stable(sub_vendor) && $stable(sub_id) &&
                                   $stable(route_map) && $stable(pm_cap)));

    assert_bus_keeps_context_R3: assert property (@(posedge clk) disable iff (!gbl_rst_n)
        (!bus_rst_n && !susp && pme_any) |=> $stable(pm_ctl[0][12:8]) && $stable(pm_ctl[NUM_FUNC-1][12:8]));

    assert_bus_clears_context_R4: assert property (@(posedge clk) disable iff (!gbl_rst_n)
        (!bus_rst_n && !susp && !pme_any) |=> ctx_zero);

    assert_suspend_holds_R6: assert property (@(posedge clk) disable iff (!gbl_rst_n && !susp)
        susp |=> ($stable(sub_vendor) && $stable(sub_id) && $stable(route_map) &&
                  $stable(pm_cap) && $stable(pm_ctl) && $stable(gp_ctrl)));

    assert_d3_flag_R7: assert property (@(posedge clk) disable iff (!gbl_rst_n)
        d3_flag |-> (pme_any && all_d3));

endmodule

bind rstctx_bank rstctx_chk #(
    .NUM_FUNC  (NUM_FUNC),
    .DATA_W    (DATA_W),
    .ROUTE_DEF (ROUTE_DEF)
) i_chk (
    .clk        (clk),
    .gbl_rst_n  (gbl_rst_n),
    .bus_rst_n  (bus_rst_n),
    .susp       (susp),
    .sub_vendor (sub_vendor),
    .sub_id     (sub_id),
    .route_map  (route_map),
    .pm_cap     (pm_cap),
    .pm_ctl     (pm_ctl),
    .gp_ctrl    (gp_ctrl),
    .d3_flag    (d3_flag)
);

// File: tb/test_rstctx_bank.sv
module test_rstctx_bank;

    localparam int        CLK_PERIOD = 10;
    localparam int        NF         = 2;
    localparam int        DW         = 28;
    localparam int        SYNC       = 2;
    localparam logic [DW-1:0] RDEF   = 28'h0001000;

    logic               clk = 1'b0;
    logic               gbl_rst_n;
    logic               bus_rst_n;
    logic               susp;
    logic               wr_en;
    logic [2:0]         wr_sel;
    logic [DW-1:0]      wr_data;
    logic [15:0]        sub_vendor;
    logic [15:0]        sub_id;
    logic [DW-1:0]      route_map;
    logic [15:0]        pm_cap;
    logic [NF-1:0][15:0] pm_ctl;
    logic [15:0]        gp_ctrl;
    logic               d3_flag;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstctx_bank i_rstctx_bank (
        .clk        (clk),
        .gbl_rst_n  (gbl_rst_n),
        .bus_rst_n  (bus_rst_n),
        .susp       (susp),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .sub_vendor (sub_vendor),
        .sub_id     (sub_id),
        .route_map  (route_map),
        .pm_cap     (pm_cap),
        .pm_ctl     (pm_ctl),
        .gp_ctrl    (gp_ctrl),
        .d3_flag    (d3_flag)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0]   m_sv, m_si, m_ctrl;
    logic [DW-1:0] m_route;
    logic          m_d3c;
    logic          m_pen  [NF];
    logic [3:0]    m_dsel [NF];
    logic [1:0]    m_ps   [NF];
    int            g_cnt = 0;
    int            b_cnt = 0;

    task automatic m_defaults();
        m_sv = 0; m_si = 0; m_ctrl = 0; m_route = RDEF; m_d3c = 1'b1;
        for (int f = 0; f < NF; f++) begin
            m_pen[f] = 0; m_dsel[f] = 0; m_ps[f] = 0;
        end
    endtask

    initial m_defaults();

    always @(posedge clk) begin
        bit g_now, b_now, any;
        if (!susp) begin
            g_now = !gbl_rst_n || (g_cnt < SYNC);
            b_now = !bus_rst_n || (b_cnt < SYNC) || g_now;
            if (g_now) begin
                m_defaults();
            end else if (b_now) begin
                any = 0;
                for (int f = 0; f < NF; f++) any = any | m_pen[f];
                m_ctrl = 0;
                for (int f = 0; f < NF; f++) begin
                    m_ps[f] = 0;
                    if (!any) begin
                        m_pen[f] = 0; m_dsel[f] = 0;
                    end
                end
            end else if (wr_en) begin
                case (wr_sel)
                    3'd0: m_sv    = wr_data[15:0];
                    3'd1: m_si    = wr_data[15:0];
                    3'd2: m_route = wr_data;
                    3'd3: m_d3c   = wr_data[15];
                    3'd4: m_ctrl  = wr_data[15:0];
                    3'd5, 3'd6: begin
                        m_pen [wr_sel - 5] = wr_data[8];
                        m_dsel[wr_sel - 5] = wr_data[12:9];
                        m_ps  [wr_sel - 5] = wr_data[1:0];
                    end
                    default: ;
                endcase
            end
            g_cnt = !gbl_rst_n ? 0 : ((g_cnt < SYNC) ? g_cnt + 1 : g_cnt);
            b_cnt = !bus_rst_n ? 0 : ((b_cnt < SYNC) ? b_cnt + 1 : b_cnt);
        end
    end

    // ---------------- comparison, every cycle ----------------
    task automatic chk(string name, logic [31:0] act, logic [31:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s: actual %h expected %h", cur_req, name, act, exp);
            bad = 1'b1;
        end
    endtask

    always begin
        bit          bad;
        bit          any, all3;
        logic [15:0] e_ctl;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!done) begin
            bad  = 0;
            any  = 0;
            all3 = 1;
            chk("sub_vendor", 32'(sub_vendor), 32'(m_sv), bad);
            chk("sub_id", 32'(sub_id), 32'(m_si), bad);
            chk("route_map", 32'(route_map), 32'(m_route), bad);
            chk("gp_ctrl", 32'(gp_ctrl), 32'(m_ctrl), bad);
            // R8: bit15 and bit4 = support bit, bits 2:0 = 010
            chk("pm_cap", 32'(pm_cap), 32'({m_d3c, 10'b0, m_d3c, 1'b0, 3'b010}), bad);
            for (int f = 0; f < NF; f++) begin
                e_ctl = 16'h0;
                e_ctl[12:9] = m_dsel[f];
                e_ctl[8]    = m_pen[f];
                e_ctl[1:0]  = m_ps[f];
                chk("pm_ctl", 32'(pm_ctl[f]), 32'(e_ctl), bad);
                any  = any | m_pen[f];
                all3 = all3 & (m_ps[f] == 2'd3);
            end
            chk("d3_flag", 32'(d3_flag), 32'(any & all3), bad);
            n_vec++;
            if (bad) n_fail++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int sel, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        gbl_rst_n = 0; bus_rst_n = 0; susp = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0;

        // R1: reset state
        cur_req = "R1";
        idle(3);

        // R9: writes during the synchroniser release are dropped
        cur_req = "R9";
        @(negedge clk);
        gbl_rst_n = 1; bus_rst_n = 1;
        wr_en = 1; wr_sel = 3'd4; wr_data = 28'h1111;
        @(negedge clk); wr_data = 28'h2222;
        @(negedge clk); wr_data = 28'h3333;
        @(negedge clk); wr_en = 0;
        idle(1);

        // R10: write map and unused bits
        cur_req = "R10";
        wr(0, 28'hFFABCD);
        wr(1, 28'h001234);
        wr(2, 28'h0ABCDEF);
        wr(4, 28'h005A5A);
        wr(5, 28'h0001A03);
        wr(6, 28'hFFFFFFF);
        wr(6, 28'h0000002);

        // R8: only bit 15 of the capability word is writable
        cur_req = "R8";
        wr(3, 28'h0007FFF);
        wr(3, 28'h0008000);

        // R3, R2, R5: bus reset with wake enabled
        cur_req = "R3";
        wr(5, 28'h0001303);
        wr(6, 28'h0000601);
        wr(4, 28'h00C3C3);
        @(negedge clk); bus_rst_n = 0;
        idle(3);
        cur_req = "R2";
        @(negedge clk); bus_rst_n = 1;
        cur_req = "R5";
        idle(3);

        // R4: bus reset with wake disabled
        cur_req = "R4";
        wr(5, 28'h0001E02);
        wr(6, 28'h0000603);
        @(negedge clk); bus_rst_n = 0;
        idle(2);
        @(negedge clk); bus_rst_n = 1;
        idle(3);

        // R7: deep-state flag
        cur_req = "R7";
        wr(5, 28'h0000003);
        wr(6, 28'h0000003);
        wr(5, 28'h0000103);
        wr(6, 28'h0000002);
        wr(6, 28'h0000003);
        wr(4, 28'h0000777);
        idle(1);

        // R6: suspend masks resets and writes
        cur_req = "R6";
        @(negedge clk); susp = 1;
        idle(2);
        @(negedge clk); gbl_rst_n = 0; bus_rst_n = 0;
        idle(2);
        wr(4, 28'h0000999);
        wr(5, 28'h0000000);
        @(negedge clk); gbl_rst_n = 1; bus_rst_n = 1;
        idle(2);
        @(negedge clk); susp = 0;
        idle(3);

        // R1: global reset clears context even with wake enabled
        cur_req = "R1";
        @(negedge clk); gbl_rst_n = 0; bus_rst_n = 0;
        idle(2);

        // R11: bus reset held past global release
        cur_req = "R11";
        @(negedge clk); gbl_rst_n = 1;
        for (int i = 0; i < 5; i++) wr(4, 28'(16'h0100 + i));
        @(negedge clk); bus_rst_n = 1;
        idle(3);
        wr(4, 28'h0000BEEF);
        wr(5, 28'h0000101);
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule